// File: doc/BRIEF.md
# Three-Bit Gray Sequence Counter

This block is a free-running synchronous counter whose three-bit output walks a reflected Gray cycle, so that from one clock to the next only a single output bit flips. Each state bit lives in its own JK-style storage cell. The J and K inputs of each cell come from fixed, minimized excitation equations that look only at the present state. No binary count is kept anywhere inside.

Alongside the state, an eight-bit decode output sets one bit high to mark where the counter is in its cycle. The bit index is the position in the sequence, not the binary value of the code. The reset input is active low and takes effect without a clock. Its release passes through a two-stage synchronizer, so counting starts cleanly on a clock edge. A parameter can remove the decode logic; in that case the decode output is held at zero.

Top module: `jk_gray_counter`

## Requirements
- R1: While rst_n is low, gray_q reads 3'b000 and pos_onehot reads 8'b0000_0001.
- R2: After rst_n rises between clock edges, gray_q stays 3'b000 across the first two rising edges and first advances, to 3'b001, on the third.
- R3: Once counting, each rising edge moves gray_q one step along the cycle 000, 001, 011, 010, 110, 111, 101, 100.
- R4: Once counting, successive values of gray_q differ in exactly one bit.
- R5: From 3'b100 the next rising edge returns gray_q to 3'b000.
- R6: pos_onehot has exactly one bit set, at index p, where p is the position of gray_q in the R3 cycle (000 gives 0, 001 gives 1, 011 gives 2, 010 gives 3, 110 gives 4, 111 gives 5, 101 gives 6, 100 gives 7).
- R7: Pulling rst_n low between clock edges forces gray_q to 3'b000 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Reset, active low; asserts asynchronously, releases through a synchronizer |
| gray_q | output | 3 | Present Gray state, taken straight from the storage cells |
| pos_onehot | output | 8 | Active-high one-hot marker of the sequence position |

## Verification
Both outputs are driven combinationally from the storage cells. A new state and its decode therefore appear together right after the rising edge that produces them, and the bench samples them on the following falling edge. When reset is released, the bench waits for the two synchronizer edges and expects the first step on the third edge. Its model counts edges since the release, so it never relies on a fixed delay. A reset pulse is applied partway through a cycle, and the outputs are checked a moment later, before any edge occurs, so that the asynchronous clear is seen on its own.

// File: rtl/gray3_pkg.sv
package gray3_pkg;
  localparam int unsigned STATE_W = 3;
  localparam int unsigned POS_N   = 1 << STATE_W;
  localparam int unsigned POS_W   = $clog2(POS_N);

  typedef logic [STATE_W-1:0] gstate_t;
  typedef logic [POS_W-1:0]   gpos_t;

  // Position in the reflected cycle: prefix XOR from the top bit down.
  function automatic gpos_t gray_to_pos(input gstate_t g);
    gpos_t p;
    p[POS_W-1] = g[STATE_W-1];
    for (int i = POS_W-2; i >= 0; i--) begin
      p[i] = p[i+1] ^ g[i];
    end
    return p;
  endfunction

  function automatic gstate_t pos_to_gray(input gpos_t p);
    return gstate_t'(p ^ (p >> 1));
  endfunction
endpackage

// File: rtl/gray3_rst_sync.sv
module gray3_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gray3_jk_cell.sv
module gray3_jk_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic j,
  input  logic k,
  output logic q
);
  logic q_d;

  // Hold, clear, set or toggle, chosen by the J/K pair.
  always_comb begin
    unique case ({j, k})
      2'b00:   q_d = q;
      2'b01:   q_d = 1'b0;
      2'b10:   q_d = 1'b1;
      default: q_d = ~q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      q <= q_d;
    end
  end
endmodule

// File: rtl/gray3_excite.sv
module gray3_excite
  import gray3_pkg::*;
(
  input  gstate_t cur,
  output gstate_t j_vec,
  output gstate_t k_vec
);
  // Minimized excitation terms; unused minterms were treated as free.
  always_comb begin
    j_vec[2] =  cur[1] & ~cur[0];
    k_vec[2] = ~cur[1] & ~cur[0];
    j_vec[1] = ~cur[2] &  cur[0];
    k_vec[1] =  cur[2] &  cur[0];
    j_vec[0] = ~(cur[2] ^ cur[1]);
    k_vec[0] =   cur[2] ^ cur[1];
  end
endmodule

// File: rtl/gray3_decode.sv
module gray3_decode
  import gray3_pkg::*;
#(
  parameter bit DECODE_EN = 1'b1
) (
  input  gstate_t          cur,
  output logic [POS_N-1:0] marks
);
  generate
    if (DECODE_EN) begin : g_dec
      gpos_t pos;
      assign pos = gray_to_pos(cur);
      for (genvar i = 0; i < POS_N; i++) begin : g_bit
        assign marks[i] = (pos == gpos_t'(i));
      end
    end else begin : g_nodec
      assign marks = '0;
    end
  endgenerate
endmodule

// File: rtl/jk_gray_counter.sv
module jk_gray_counter
  import gray3_pkg::*;
#(
  parameter bit          DECODE_EN   = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [2:0]       gray_q,
  output logic [POS_N-1:0] pos_onehot
);
  logic    run_rst_n;
  gstate_t state;
  gstate_t j_vec;
  gstate_t k_vec;

  gray3_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (run_rst_n)
  );

  gray3_excite u_excite (
    .cur   (state),
    .j_vec (j_vec),
    .k_vec (k_vec)
  );

  for (genvar b = 0; b < STATE_W; b++) begin : g_cell
    gray3_jk_cell u_cell (
      .clk   (clk),
      .rst_n (run_rst_n),
      .j     (j_vec[b]),
      .k     (k_vec[b]),
      .q     (state[b])
    );
  end

  gray3_decode #(.DECODE_EN(DECODE_EN)) u_decode (
    .cur   (state),
    .marks (pos_onehot)
  );

  assign gray_q = state;
endmodule

// File: rtl/jk_gray_counter_chk.sv
module jk_gray_counter_chk
  import gray3_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             run_n,
  input logic [2:0]       q,
  input logic [POS_N-1:0] dec
);
  // R2
  held_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_n |=> q == 3'b000);

  // R3
  next_step_chk: assert property (@(posedge clk) disable iff (!run_n)
    $past(run_n) |-> q == pos_to_gray(gray_to_pos($past(q)) + 1'b1));

  // R4
  one_bit_flip_chk: assert property (@(posedge clk) disable iff (!run_n)
    $past(run_n) |-> $countones(q ^ $past(q)) == 1);

  // R5
  wrap_home_chk: assert property (@(posedge clk) disable iff (!run_n)
    ($past(run_n) && $past(q) == 3'b100) |-> q == 3'b000);

  // R6
  single_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dec) == 1 && dec[gray_to_pos(q)]);
endmodule

bind jk_gray_counter jk_gray_counter_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .run_n (run_rst_n),
  .q     (gray_q),
  .dec   (pos_onehot)
);

// File: tb/test_jk_gray_counter.sv
`timescale 1ns/1ps
module test_jk_gray_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] gray_q;
  logic [7:0] pos_onehot;

  int checks = 0;
  int errors = 0;
  int pos = 0;
  int since_rel = 0;
  logic [2:0] prev_q = 3'b000;
  bit advanced = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  jk_gray_counter i_jk_gray_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .gray_q     (gray_q),
    .pos_onehot (pos_onehot)
  );

  function automatic logic [2:0] exp_gray(input int p);
    return 3'(p ^ (p >> 1));
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_all();
    check("R3", {5'b0, gray_q}, {5'b0, exp_gray(pos)});
    check("R6", pos_onehot, 8'(1 << pos));
    if (advanced) begin
      check("R4", 8'($countones(gray_q ^ prev_q)), 8'd1);
      if (prev_q == 3'b100) check("R5", {5'b0, gray_q}, 8'd0);
    end
  endtask

  task automatic step();
    @(posedge clk);
    advanced = 1'b0;
    if (rst_n) begin
      if (since_rel >= 2) begin
        pos = (pos + 1) % 8;
        advanced = 1'b1;
      end
      if (since_rel < 2) since_rel++;
    end
    @(negedge clk);
    check_all();
    prev_q = gray_q;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    since_rel = 0;
    // R2: two edges of holding, then a step
    step(); check("R2", {5'b0, gray_q}, 8'd0);
    step(); check("R2", {5'b0, gray_q}, 8'd0);
    step(); check("R2", {5'b0, gray_q}, 8'd1);
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    // R7: cleared before any clock edge
    check("R7", {5'b0, gray_q}, 8'd0);
    pos = 0;
    since_rel = 0;
    prev_q = 3'b000;
    release_reset();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: outputs held at the home state during reset
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
      check("R1", {5'b0, gray_q}, 8'd0);
      check("R1", pos_onehot, 8'b0000_0001);
    end
    release_reset();
    // Directed: two full laps, covering every position and the wrap (R3, R5)
    repeat (16) step();
    // Directed: reset right after the wrap point
    while (pos != 7) step();
    step();
    pulse_reset();
    // Random run lengths with reset pulses at random positions (R4, R7)
    for (int seg = 0; seg < 40; seg++) begin
      int len;
      len = $urandom_range(1, 30);
      for (int i = 0; i < len; i++) step();
      if ($urandom_range(0, 2) == 0) pulse_reset();
    end
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule